// File: doc/BRIEF.md
# ADC Sample and Convert Sequencer

This block schedules the acquisition windows and conversions of one successive-approximation converter that several start-of-conversion slots share. Each slot raises a one-cycle trigger and has its own 6-bit acquisition setting. The block queues the triggers and serves them one at a time, lowest slot index first. For each one it opens a sample window and then a conversion phase of fixed length. When the modelled result is ready it gives a one-cycle end-of-conversion pulse that carries the slot index. The analog converter itself is represented only by that fixed conversion latency.

The converter clock is either the system clock or half of it. All timing is counted in system-clock cycles, so every converter cycle lasts one system cycle at full rate and two at half rate. In overlap mode a new window can open while the previous conversion is still running. In sequential mode a window opens only when the conversion stage is free. Each setting is checked against a table of allowed values that depends on the clock rate and the mode. A setting outside that table is still carried out, but it raises a sticky flag that records the slot. A trigger for a slot that is already queued is dropped and counted.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, sampleWin, convBusy, eocPulse, badSetFlag and ovfCnt are all 0.
- R2: If the block is idle and a trigger is registered at rising edge N, sampleWin is high from edge N+1 for (setting+1)*D system cycles. D is 1 when halfRateEn=0 and 2 when halfRateEn=1.
- R3: A conversion lasts 13*D system cycles. If the converter is idle or in its last cycle, convBusy starts at the edge where the window closes.
- R4: eocPulse is high for exactly one cycle, the first cycle after the last convBusy cycle of that conversion, and eocSlot then holds the slot index.
- R5: In sequential mode (overlapEn=0) the next queued window opens at the same edge that the previous conversion ends, so sampleWin and convBusy are never high together.
- R6: In overlap mode (overlapEn=1) the next queued window opens one cycle after the previous conversion starts. A window that closes while the converter is busy is held, with no new window opened, and its conversion starts at the edge where the converter frees.
- R7: Each slot k uses its own setting, taken from acqSet bits [6k+5:6k].
- R8: Queued triggers are served one at a time in ascending slot-index order.
- R9: At half rate (halfRateEn=1), settings 6 to 63 are valid in both modes and 0 to 5 are invalid.
- R10: At full rate in overlap mode, the valid settings are 6-10, 12-14, 20-23, 25-27, 33-36, 38-40, 46-49, 51-53 and 59-62.
- R11: At full rate in sequential mode, the valid settings are 6-16, 18-29, 31-42, 44-45 and 57-63.
- R12: An invalid setting still runs a full window and conversion. It sets badSetFlag at the edge its window opens. badSetSlot records the first offender since the last clear. An errClr pulse clears the flag, and a new offender in the same cycle wins over the clear.
- R13: A trigger for a slot that is already queued, and not being granted in that cycle, is dropped and adds one to ovfCnt. ovfCnt saturates at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| halfRateEn | input | 1 | 1 runs the converter clock at half the system rate |
| overlapEn | input | 1 | 1 lets sampling overlap the previous conversion |
| trig | input | 4 | Per-slot start-of-conversion pulses |
| acqSet | input | 24 | Per-slot acquisition settings, 6 bits per slot, slot 0 in the low bits |
| errClr | input | 1 | Write-one-to-clear pulse for the invalid-setting flag |
| sampleWin | output | 1 | High during an acquisition window |
| convBusy | output | 1 | High while a conversion runs |
| eocPulse | output | 1 | One-cycle end-of-conversion pulse |
| eocSlot | output | 2 | Slot index of the finished conversion |
| badSetFlag | output | 1 | Sticky invalid-setting flag |
| badSetSlot | output | 2 | Slot of the first invalid setting since the last clear |
| ovfCnt | output | 8 | Saturating count of dropped triggers |

## Verification
The first pattern is a sweep over every setting from 0 to 63, at both clock rates and in both modes, with each run triggering a single slot. It measures the window length, the conversion length and the pulse latency, and it checks the flag against the validity table. This shows whether the window arithmetic, the clock halving and each row of the table are right. The second pattern is a simultaneous burst on three slots with mixed settings, run in all four rate and mode combinations. Its exact pulse cycles separate ascending-order service, strictly sequential timing, overlapped timing, and the hold of a window that closes while the converter is still busy. The third pattern re-triggers slots that are already queued, which shows whether drops are counted, whether a slot that is currently being served accepts a new trigger, and whether the counter saturates.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Handshake strobes from the sequencing control to the datapath.
  typedef struct packed {
    logic sampStart;     // window opens at this edge
    logic sampEnd;       // window closes at this edge
    logic convStart;     // conversion begins at this edge
    logic convFromHold;  // the beginning conversion comes from the held window
    logic convEnd;       // conversion finishes at this edge
  } seqStrobes_t;

  function automatic logic inRange(input int unsigned s, input int unsigned lo,
                                   input int unsigned hi);
    return (s >= lo) && (s <= hi);
  endfunction

  // Allowed acquisition settings per clock rate and mode.
  function automatic logic acqSettingOk(input int unsigned s, input logic halfRate,
                                        input logic overlap);
    logic ok;
    if (s < 6 || s > 63) begin
      ok = 1'b0;
    end else if (halfRate) begin
      ok = 1'b1;
    end else if (overlap) begin
      ok = inRange(s, 6, 10)  || inRange(s, 12, 14) || inRange(s, 20, 23) ||
           inRange(s, 25, 27) || inRange(s, 33, 36) || inRange(s, 38, 40) ||
           inRange(s, 46, 49) || inRange(s, 51, 53) || inRange(s, 59, 62);
    end else begin
      ok = inRange(s, 6, 16)  || inRange(s, 18, 29) || inRange(s, 31, 42) ||
           inRange(s, 44, 45) || inRange(s, 57, 63);
    end
    return ok;
  endfunction

endpackage

// File: rtl/adc_seq_arb.sv
module adc_seq_arb #(
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W    = 2,
  parameter int OVF_W     = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SLOTS-1:0] trig,
  input  logic                 sampStart,
  output logic                 pendAny,
  output logic [SLOT_W-1:0]    grantSlot,
  output logic [OVF_W-1:0]     ovfCnt
);

  logic [NUM_SLOTS-1:0] pendQ;
  logic [NUM_SLOTS-1:0] grantMask;
  logic [NUM_SLOTS-1:0] dropMask;
  logic [OVF_W:0]       ovfSum;
  logic [OVF_W-1:0]     ovfQ;

  // Lowest pending index wins.
  always_comb begin
    grantSlot = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (pendQ[i]) grantSlot = SLOT_W'(i);
    end
  end

  assign pendAny   = |pendQ;
  assign grantMask = sampStart ? (NUM_SLOTS'(1) << grantSlot) : '0;
  assign dropMask  = trig & pendQ & ~grantMask;
  assign ovfSum    = {1'b0, ovfQ} + (OVF_W + 1)'($countones(dropMask));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
      ovfQ  <= '0;
    end else begin
      pendQ <= (pendQ & ~grantMask) | trig;
      ovfQ  <= ovfSum[OVF_W] ? '1 : ovfSum[OVF_W-1:0];
    end
  end

  assign ovfCnt = ovfQ;

  // R13
  ovf_monotonic_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfQ >= $past(ovfQ));

  // R8
  grant_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampStart |-> pendQ[grantSlot]);

endmodule

// File: rtl/adc_seq_ctl.sv
module adc_seq_ctl
  import adc_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        overlapEn,
  input  logic        pendAny,
  input  logic        sampCntZero,
  input  logic        convCntZero,
  output seqStrobes_t strb,
  output logic        sampActive,
  output logic        convActive
);

  logic holdValid;
  logic sampDone;
  logic convDone;
  logic convFree;

  assign sampDone = sampActive && sampCntZero;
  assign convDone = convActive && convCntZero;
  assign convFree = !convActive || convDone;

  always_comb begin
    strb              = '0;
    strb.sampStart    = pendAny && !sampActive && !holdValid && (overlapEn || convFree);
    strb.sampEnd      = sampDone;
    strb.convFromHold = holdValid && convFree;
    strb.convStart    = (sampDone && convFree) || strb.convFromHold;
    strb.convEnd      = convDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampActive <= 1'b0;
      convActive <= 1'b0;
      holdValid  <= 1'b0;
    end else begin
      if (strb.sampStart)    sampActive <= 1'b1;
      else if (strb.sampEnd) sampActive <= 1'b0;

      if (strb.convStart)    convActive <= 1'b1;
      else if (convDone)     convActive <= 1'b0;

      if (sampDone && !convFree) holdValid <= 1'b1;
      else if (strb.convFromHold) holdValid <= 1'b0;
    end
  end

  // R5
  nonovl_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sampActive) && !$past(overlapEn) |-> !convActive);

  // R6
  hold_blocks_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdValid |-> !sampActive);

  // R3
  conv_follows_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convActive) |-> $past(sampActive) || $past(holdValid));

endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int NUM_SLOTS   = 4,
  parameter int SLOT_W      = 2,
  parameter int ACQ_W       = 6,
  parameter int CONV_CYCLES = 13,
  parameter int TIME_W      = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       halfRateEn,
  input  logic                       overlapEn,
  input  logic [NUM_SLOTS*ACQ_W-1:0] acqSet,
  input  logic [SLOT_W-1:0]          grantSlot,
  input  logic                       errClr,
  input  seqStrobes_t                strb,
  input  logic                       sampActive,
  input  logic                       convActive,
  output logic                       sampCntZero,
  output logic                       convCntZero,
  output logic                       eocPulse,
  output logic [SLOT_W-1:0]          eocSlot,
  output logic                       badSetFlag,
  output logic [SLOT_W-1:0]          badSetSlot
);

  logic [ACQ_W-1:0]  acqArr [NUM_SLOTS];
  logic [ACQ_W-1:0]  acqSel;
  logic [TIME_W-1:0] winLen;
  logic [TIME_W-1:0] winLoad;
  logic [TIME_W-1:0] convLoad;
  logic [TIME_W-1:0] sampCnt;
  logic [TIME_W-1:0] convCnt;
  logic [SLOT_W-1:0] sampSlot;
  logic [SLOT_W-1:0] holdSlot;
  logic [SLOT_W-1:0] convSlot;
  logic              setOk;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_acq
    assign acqArr[g] = acqSet[g*ACQ_W +: ACQ_W];
  end

  assign acqSel   = acqArr[grantSlot];
  assign winLen   = (TIME_W'(acqSel) + TIME_W'(1)) << halfRateEn;
  assign winLoad  = winLen - TIME_W'(1);
  assign convLoad = (TIME_W'(CONV_CYCLES) << halfRateEn) - TIME_W'(1);
  assign setOk    = acqSettingOk(32'(acqSel), halfRateEn, overlapEn);

  assign sampCntZero = (sampCnt == '0);
  assign convCntZero = (convCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampCnt    <= '0;
      convCnt    <= '0;
      sampSlot   <= '0;
      holdSlot   <= '0;
      convSlot   <= '0;
      eocPulse   <= 1'b0;
      eocSlot    <= '0;
      badSetFlag <= 1'b0;
      badSetSlot <= '0;
    end else begin
      if (strb.sampStart) begin
        sampCnt  <= winLoad;
        sampSlot <= grantSlot;
      end else if (sampActive && !sampCntZero) begin
        sampCnt <= sampCnt - TIME_W'(1);
      end

      if (strb.sampEnd && !strb.convStart) holdSlot <= sampSlot;

      if (strb.convStart) begin
        convCnt  <= convLoad;
        convSlot <= strb.convFromHold ? holdSlot : sampSlot;
      end else if (convActive && !convCntZero) begin
        convCnt <= convCnt - TIME_W'(1);
      end

      eocPulse <= strb.convEnd;
      if (strb.convEnd) eocSlot <= convSlot;

      if (strb.sampStart && !setOk) begin
        badSetFlag <= 1'b1;
        if (!badSetFlag || errClr) badSetSlot <= grantSlot;
      end else if (errClr) begin
        badSetFlag <= 1'b0;
      end
    end
  end

  // R4
  eoc_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    eocPulse |=> !eocPulse);

  // R4
  eoc_after_conv_chk: assert property (@(posedge clk) disable iff (!rstN)
    eocPulse |-> $past(convActive));

  // R12
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(badSetFlag) && !$past(errClr) |-> badSetFlag && $stable(badSetSlot));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_SLOTS   = 4,
  parameter int ACQ_W       = 6,
  parameter int CONV_CYCLES = 13,
  parameter int OVF_W       = 8,
  localparam int SLOT_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int TIME_W     = (ACQ_W + 2 > $clog2(CONV_CYCLES) + 2) ?
                              ACQ_W + 2 : $clog2(CONV_CYCLES) + 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       halfRateEn,
  input  logic                       overlapEn,
  input  logic [NUM_SLOTS-1:0]       trig,
  input  logic [NUM_SLOTS*ACQ_W-1:0] acqSet,
  input  logic                       errClr,
  output logic                       sampleWin,
  output logic                       convBusy,
  output logic                       eocPulse,
  output logic [SLOT_W-1:0]          eocSlot,
  output logic                       badSetFlag,
  output logic [SLOT_W-1:0]          badSetSlot,
  output logic [OVF_W-1:0]           ovfCnt
);

  seqStrobes_t       strb;
  logic              pendAny;
  logic [SLOT_W-1:0] grantSlot;
  logic              sampActive;
  logic              convActive;
  logic              sampCntZero;
  logic              convCntZero;

  adc_seq_arb #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .OVF_W(OVF_W)) u_arb (
    .clk(clk), .rstN(rstN), .trig(trig), .sampStart(strb.sampStart),
    .pendAny(pendAny), .grantSlot(grantSlot), .ovfCnt(ovfCnt)
  );

  adc_seq_ctl u_ctl (
    .clk(clk), .rstN(rstN), .overlapEn(overlapEn), .pendAny(pendAny),
    .sampCntZero(sampCntZero), .convCntZero(convCntZero), .strb(strb),
    .sampActive(sampActive), .convActive(convActive)
  );

  adc_seq_dp #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .ACQ_W(ACQ_W),
               .CONV_CYCLES(CONV_CYCLES), .TIME_W(TIME_W)) u_dp (
    .clk(clk), .rstN(rstN), .halfRateEn(halfRateEn), .overlapEn(overlapEn),
    .acqSet(acqSet), .grantSlot(grantSlot), .errClr(errClr), .strb(strb),
    .sampActive(sampActive), .convActive(convActive),
    .sampCntZero(sampCntZero), .convCntZero(convCntZero),
    .eocPulse(eocPulse), .eocSlot(eocSlot),
    .badSetFlag(badSetFlag), .badSetSlot(badSetSlot)
  );

  assign sampleWin = sampActive;
  assign convBusy  = convActive;

  // R12
  flag_on_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(badSetFlag) |-> $rose(sampleWin));

endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  localparam int N = 4;
  localparam int AW = 6;
  localparam int CONV = 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic halfRateEn = 1'b0;
  logic overlapEn = 1'b0;
  logic [N-1:0] trig = '0;
  logic [N*AW-1:0] acqSet = '0;
  logic errClr = 1'b0;
  logic sampleWin, convBusy, eocPulse, badSetFlag;
  logic [1:0] eocSlot, badSetSlot;
  logic [7:0] ovfCnt;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  adc_seq_ctrl u_dut (
    .clk(clk), .rstN(rstN), .halfRateEn(halfRateEn), .overlapEn(overlapEn),
    .trig(trig), .acqSet(acqSet), .errClr(errClr), .sampleWin(sampleWin),
    .convBusy(convBusy), .eocPulse(eocPulse), .eocSlot(eocSlot),
    .badSetFlag(badSetFlag), .badSetSlot(badSetSlot), .ovfCnt(ovfCnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit refValid(input int s, input bit half, input bit ovl);
    if (s < 6 || s > 63) return 1'b0;
    if (half) return 1'b1;
    if (ovl) return s inside {[6:10], [12:14], [20:23], [25:27], [33:36],
                              [38:40], [46:49], [51:53], [59:62]};
    return s inside {[6:16], [18:29], [31:42], [44:45], [57:63]};
  endfunction

  task automatic setAcq(input int slot, input int v);
    acqSet[slot*AW +: AW] = v[AW-1:0];
  endtask

  // Leaves the bench at the falling edge right after the sampling edge.
  task automatic pulseTrig(input logic [N-1:0] m);
    @(negedge clk);
    trig = m;
    @(negedge clk);
    trig = '0;
  endtask

  task automatic clearFlag();
    @(negedge clk);
    errClr = 1'b1;
    @(negedge clk);
    errClr = 1'b0;
  endtask

  task automatic runSingle(input int slot, input int acq, input bit half, input bit ovl);
    int w, c, winFirst, winCnt, convFirst, convCnt, eocK, eocN, eocS;
    string tag;
    halfRateEn = half;
    overlapEn = ovl;
    setAcq(slot, acq);
    w = (acq + 1) * (half ? 2 : 1);
    c = CONV * (half ? 2 : 1);
    winFirst = -1; winCnt = 0; convFirst = -1; convCnt = 0;
    eocK = -1; eocN = 0; eocS = -1;
    pulseTrig(N'(1) << slot);
    for (int k = 1; k <= w + c + 3; k++) begin
      @(negedge clk);
      if (sampleWin) begin if (winFirst < 0) winFirst = k; winCnt++; end
      if (convBusy) begin if (convFirst < 0) convFirst = k; convCnt++; end
      if (eocPulse) begin eocN++; eocK = k; eocS = int'(eocSlot); end
    end
    chk("R2 window start", winFirst, 1);
    chk("R2 window length", winCnt, w);
    chk("R3 conversion start", convFirst, w + 1);
    chk("R3 conversion length", convCnt, c);
    chk("R4 eoc cycle", eocK, w + c + 1);
    chk("R4 eoc count", eocN, 1);
    chk("R7 eoc slot", eocS, slot);
    tag = half ? "R9 validity" : (ovl ? "R10 validity" : "R11 validity");
    chk(tag, int'(badSetFlag), int'(!refValid(acq, half, ovl)));
    if (!refValid(acq, half, ovl)) begin
      chk("R12 offender slot", int'(badSetSlot), slot);
      clearFlag();
      chk("R12 flag cleared", int'(badSetFlag), 0);
    end
  endtask

  task automatic runTriple(input bit ovl, input bit half);
    int d, c, s, cs, prevCs, both, n;
    int w[3];
    int expK[3];
    int gotK[3];
    int gotS[3];
    d = half ? 2 : 1;
    c = CONV * d;
    halfRateEn = half;
    overlapEn = ovl;
    setAcq(0, 63); setAcq(1, 6); setAcq(2, 6); setAcq(3, 20);
    w[0] = 7 * d; w[1] = 7 * d; w[2] = 21 * d;
    s = 1;
    prevCs = -1000;
    for (int j = 0; j < 3; j++) begin
      cs = s + w[j];
      if (ovl && cs < prevCs + c) cs = prevCs + c;
      expK[j] = cs + c;
      prevCs = cs;
      s = ovl ? cs + 1 : cs + c;
    end
    both = 0; n = 0;
    for (int j = 0; j < 3; j++) begin gotK[j] = -1; gotS[j] = -1; end
    pulseTrig(4'b1110);
    for (int k = 1; k <= 400; k++) begin
      @(negedge clk);
      if (sampleWin && convBusy) both++;
      if (eocPulse) begin
        if (n < 3) begin gotK[n] = k; gotS[n] = int'(eocSlot); end
        n++;
      end
    end
    chk("R8 eoc count", n, 3);
    for (int j = 0; j < 3; j++) begin
      chk("R8 ascending order", gotS[j], j + 1);
      chk(ovl ? "R6 overlap eoc cycle" : "R5 sequential eoc cycle", gotK[j], expK[j]);
    end
    if (ovl) chk("R6 overlap observed", int'(both > 0), 1);
    else     chk("R5 no overlap", both, 0);
    chk("R7 no flag for valid settings", int'(badSetFlag), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base, n;
    int gs[3];
    repeat (3) @(negedge clk);
    chk("R1 reset sampleWin", int'(sampleWin), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset sampleWin", int'(sampleWin), 0);
    chk("R1 reset convBusy", int'(convBusy), 0);
    chk("R1 reset eocPulse", int'(eocPulse), 0);
    chk("R1 reset badSetFlag", int'(badSetFlag), 0);
    chk("R1 reset ovfCnt", int'(ovfCnt), 0);

    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 64; a++) begin
        runSingle(a % N, a, m[1], m[0]);
      end
    end

    for (int m = 0; m < 4; m++) runTriple(m[0], m[1]);

    // R12: first offender kept, invalid settings still run
    halfRateEn = 1'b0; overlapEn = 1'b1;
    setAcq(1, 2); setAcq(2, 11);
    n = 0;
    pulseTrig(4'b0110);
    for (int k = 1; k <= 200; k++) begin
      @(negedge clk);
      if (eocPulse) n++;
    end
    chk("R12 invalid settings still convert", n, 2);
    chk("R12 flag set", int'(badSetFlag), 1);
    chk("R12 first offender", int'(badSetSlot), 1);
    clearFlag();
    chk("R12 cleared", int'(badSetFlag), 0);

    // R13: drops of queued triggers
    halfRateEn = 1'b0; overlapEn = 1'b0;
    setAcq(2, 30); setAcq(3, 30);
    base = int'(ovfCnt);
    pulseTrig(4'b1100);
    pulseTrig(4'b1100);
    pulseTrig(4'b1000);
    chk("R13 drop count", int'(ovfCnt), base + 2);
    n = 0;
    for (int j = 0; j < 3; j++) gs[j] = -1;
    for (int k = 1; k <= 400; k++) begin
      @(negedge clk);
      if (eocPulse) begin
        if (n < 3) gs[n] = int'(eocSlot);
        n++;
      end
    end
    chk("R13 served count", n, 3);
    chk("R13 order first", gs[0], 2);
    chk("R8 retriggered slot before higher", gs[1], 2);
    chk("R8 highest last", gs[2], 3);

    setAcq(0, 63); setAcq(1, 63);
    @(negedge clk);
    trig = 4'b0011;
    repeat (300) @(negedge clk);
    trig = '0;
    @(negedge clk);
    chk("R13 saturation", int'(ovfCnt), 255);
    pulseTrig(4'b0011);
    chk("R13 stays saturated", int'(ovfCnt), 255);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule